// File: doc/BRIEF.md
# Synchronous Burst Static Memory Front End

This block sits in front of a small word-wide static memory and gives it a clocked, burst-capable access port. Every input except output enable is taken at the rising clock edge. An access begins on one of two address strobes: the processor strobe or the controller strobe. The block then loads the external address and can walk through a group of four words by stepping a 2-bit counter on the low address bits. A mode input picks the counting order. Linear order adds the count to the loaded low bits, modulo four. Interleaved order XORs the count into the loaded low bits.

Each word is 36 bits wide and is split into four 9-bit byte lanes. A global write input writes the whole word. A byte-write enable, together with one enable per lane, writes only the chosen lanes. The shared data bus is bidirectional. The block drives it only with the result of a read, and only while output enable is low. A sleep input freezes the block and releases the bus.

Top module: `bsram_front`

## Requirements
- R1: After reset the bus is released and no burst is open. A cycle with no strobe neither drives the bus nor writes the array until a selected strobe has opened a burst.
- R2: With the mode input low when the burst opens, successive advance cycles use low address bits start+1, start+2, start+3, modulo 4. Example: from 01 the order is 01,10,11,00.
- R3: With the mode input high when the burst opens, the k-th word of the burst uses low bits start XOR k. Example: from 01 the order is 01,00,11,10, and from 11 it is 11,10,01,00.
- R4: The address bits above the low two keep their loaded value for the whole burst. The mode is sampled only when an address is loaded.
- R5: The processor strobe, low with the chip fully selected, loads the external address and performs a read even when write is asserted. Asserting write on the next cycle, with advance high, writes that same address.
- R6: The processor strobe has no effect while the primary enable `en_a_n` is high. That cycle then acts as a strobe-free cycle, so with advance low it reads the next burst word.
- R7: When both strobes are low with the chip fully selected, the processor strobe wins. The cycle is a read and nothing is written.
- R8: The controller strobe, low with the chip fully selected and the processor strobe not taking effect, loads the external address. On that same edge it writes the bus data if the write decode is active, and otherwise reads.
- R9: Write decode. `gwr_n` low writes all four lanes. Otherwise, `bwe_n` low writes each lane n (bits 9n+8 to 9n) whose `lane_n[n]` is low. In every other case the cycle is a read, including `bwe_n` low with all lane enables high.
- R10: In a strobe-free cycle of an open burst with `adv_n` high, the current address is reused.
- R11: Read data for a cycle's address appears on the bus in the cycle after that edge, provided `oe_n` is low. The bus is released after write cycles, after deselect cycles (a strobe without `en_a_n` low, `en_b` high and `en_c_n` low), and while `oe_n` is high. A deselect closes the burst.
- R12: While `sleep` is high the bus is released, strobes and writes are ignored, and the open burst is kept for when `sleep` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | External word address |
| en_a_n | input | 1 | Primary chip enable, active low; gates the processor strobe |
| en_b | input | 1 | Secondary chip enable, active high |
| en_c_n | input | 1 | Third chip enable, active low |
| cpu_stb_n | input | 1 | Processor address strobe, active low |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global (whole word) write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_n | input | 4 | Per-lane write enables, active low, lane n is bits 9n+8 to 9n |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Sleep request, active high |
| ilv_mode | input | 1 | Burst order: 1 interleaved, 0 linear |
| dq | inout | 36 | Bidirectional data bus |

## Verification
The bench drives every input half a period before the rising edge. The address register feeds the array read directly, so read data for an edge is sampled at the following falling edge. For that sample the bench releases its own drivers and pulls `oe_n` low, unless it is testing `oe_n` high. A write takes effect at the edge where it is sampled. It is observed one cycle later as a released bus and later through a read of the same address. Each stored word has nonzero bits, so a released bus, read as all high-impedance or all zero, cannot be mistaken for read data.

// File: rtl/bsram_pkg.sv
// Shared widths and the address-operation type for the burst memory front end.
package bsram_pkg;
    localparam int LANE_W = 9;
    localparam int LANES  = 4;
    localparam int WORD_W = LANE_W * LANES;

    // What the burst address register does at the coming edge.
    typedef enum logic [1:0] {
        ADR_KEEP = 2'd0,
        ADR_LOAD = 2'd1,
        ADR_STEP = 2'd2
    } adr_op_e;
endpackage

// File: rtl/bsram_burst_ctr.sv
// Burst address register.
// Holds the upper address bits, the loaded low bits (base), a 2-bit count and
// the burst order latched at load time. Provides the address used by the
// current edge (cyc_addr) and the address registered by the last edge
// (cur_addr).
// Assumes ADDR_W >= 3 and that the caller never requests LOAD and STEP together.
module bsram_burst_ctr
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  adr_op_e           op,
    input  logic              ilv_mode,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int UP_W = ADDR_W - 2;

    logic [UP_W-1:0] up_q;
    logic [1:0]      base_q;
    logic [1:0]      cnt_q;
    logic            ilv_q;
    logic [1:0]      cnt_nx;

    // Low address bits for a given base and count in the latched order.
    function automatic logic [1:0] order_lo(input logic [1:0] b, input logic [1:0] c,
                                            input logic ilv);
        return ilv ? (b ^ c) : (b + c);
    endfunction

    // Registered and per-edge addresses.
    always_comb begin
        cnt_nx   = cnt_q + 2'd1;
        cur_addr = {up_q, order_lo(base_q, cnt_q, ilv_q)};
        case (op)
            ADR_LOAD: cyc_addr = ext_addr;
            ADR_STEP: cyc_addr = {up_q, order_lo(base_q, cnt_nx, ilv_q)};
            default:  cyc_addr = cur_addr;
        endcase
    end

    // Load or step the burst state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q   <= '0;
            base_q <= '0;
            cnt_q  <= '0;
            ilv_q  <= 1'b0;
        end else begin
            case (op)
                ADR_LOAD: begin
                    up_q   <= ext_addr[ADDR_W-1:2];
                    base_q <= ext_addr[1:0];
                    cnt_q  <= '0;
                    ilv_q  <= ilv_mode;
                end
                ADR_STEP: cnt_q <= cnt_nx;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    // R2
    lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ADR_STEP && !ilv_q) |=> (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));

    // R3
    ilv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ADR_STEP && ilv_q) |=> (cur_addr[0] != $past(cur_addr[0])));

    // R4
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ADR_STEP) |-> (cyc_addr[ADDR_W-1:2] == cur_addr[ADDR_W-1:2]));

    // R10
    keep_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ADR_KEEP) |=> $stable(cur_addr));
endmodule

// File: rtl/bsram_wr_decode.sv
// Write decode.
// Global write selects every lane. Otherwise the byte-write enable passes the
// active-low lane enables through. A cycle counts as a write when any lane is
// selected. Pure combinational logic with no assumptions on input timing.
module bsram_wr_decode #(
    parameter int NLANE = 4
) (
    input  logic             gwr_n,
    input  logic             bwe_n,
    input  logic [NLANE-1:0] lane_n,
    output logic             wr_cyc,
    output logic [NLANE-1:0] lane_we
);
    // Lane selection and write/read classification.
    always_comb begin
        if (!gwr_n)      lane_we = '1;
        else if (!bwe_n) lane_we = ~lane_n;
        else             lane_we = '0;
        wr_cyc = |lane_we;
    end
endmodule

// File: rtl/bsram_array.sv
// Word array with per-lane write enables.
// Synchronous write and asynchronous read. The storage is not reset, so its
// contents are undefined until written.
module bsram_array #(
    parameter int ADDR_W = 4,
    parameter int NLANE  = 4,
    parameter int LW     = 9
) (
    input  logic                clk,
    input  logic [NLANE-1:0]    we,
    input  logic [ADDR_W-1:0]   waddr,
    input  logic [NLANE*LW-1:0] wdata,
    input  logic [ADDR_W-1:0]   raddr,
    output logic [NLANE*LW-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [NLANE*LW-1:0] mem [DEPTH];

    // Lane-masked write at the clock edge.
    always_ff @(posedge clk) begin
        for (int l = 0; l < NLANE; l++) begin
            if (we[l]) mem[waddr][l*LW +: LW] <= wdata[l*LW +: LW];
        end
    end

    // Read of the registered address.
    assign rdata = mem[raddr];
endmodule

// File: rtl/bsram_front.sv
// Burst memory front end (top).
// Decodes the two strobes, chip enables, advance, sleep and write inputs at
// each rising edge into one of: load, step, hold or idle. It writes the array
// at the address this edge uses and drives the bus in the next cycle with the
// read result. oe_n and sleep gate the bus driver without a clock.
// Assumes the host releases dq whenever it expects read data.
module bsram_front
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic              cpu_stb_n,
    input  logic              ctl_stb_n,
    input  logic              adv_n,
    input  logic              gwr_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic              ilv_mode,
    inout  wire  [WORD_W-1:0] dq
);
    logic              sel_ok, cpu_go, ctl_go, start, cont;
    logic              wr_cyc, wr_fire, rd_fire;
    logic              act_q, rd_q, dq_oe;
    adr_op_e           op;
    logic [LANES-1:0]  lane_we, lane_we_eff;
    logic [ADDR_W-1:0] cyc_addr, cur_addr;
    logic [WORD_W-1:0] rdata;

    bsram_wr_decode #(.NLANE(LANES)) u_dec (
        .gwr_n  (gwr_n),
        .bwe_n  (bwe_n),
        .lane_n (lane_n),
        .wr_cyc (wr_cyc),
        .lane_we(lane_we)
    );

    // Classify this edge: strobe start, burst continuation, read or write.
    always_comb begin
        sel_ok      = !en_a_n && en_b && !en_c_n;
        cpu_go      = !sleep && !cpu_stb_n && !en_a_n;
        ctl_go      = !sleep && !cpu_go && !ctl_stb_n;
        start       = cpu_go || ctl_go;
        cont        = !sleep && !start && act_q;
        wr_fire     = (ctl_go && sel_ok && wr_cyc) || (cont && wr_cyc);
        rd_fire     = (cpu_go && sel_ok) || (ctl_go && sel_ok && !wr_cyc) || (cont && !wr_cyc);
        lane_we_eff = wr_fire ? lane_we : '0;
        if (start && sel_ok)   op = ADR_LOAD;
        else if (cont && !adv_n) op = ADR_STEP;
        else                   op = ADR_KEEP;
    end

    bsram_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .ilv_mode(ilv_mode),
        .ext_addr(addr),
        .cyc_addr(cyc_addr),
        .cur_addr(cur_addr)
    );

    bsram_array #(.ADDR_W(ADDR_W), .NLANE(LANES), .LW(LANE_W)) u_mem (
        .clk  (clk),
        .we   (lane_we_eff),
        .waddr(cyc_addr),
        .wdata(dq),
        .raddr(cur_addr),
        .rdata(rdata)
    );

    // Burst-open flag and read-pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            rd_q  <= 1'b0;
        end else begin
            if (start) act_q <= sel_ok;
            rd_q <= rd_fire;
        end
    end

    // Bus driver.
    assign dq_oe = rd_q && !oe_n && !sleep;
    assign dq    = dq_oe ? rdata : {WORD_W{1'bz}};

    // R11
    wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> !dq_oe);

    // R12
    sleep_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (lane_we_eff == '0));

    // R7
    cpu_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stb_n && !en_a_n && !sleep) |-> (lane_we_eff == '0));

    // R6
    cpu_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stb_n && en_a_n && ctl_stb_n && act_q && !adv_n && !sleep) |-> (op == ADR_STEP));
endmodule

// File: tb/bsram_front_bench.sv
// Self-checking bench for bsram_front: a burst-order vector table walked by one
// loop, followed by directed tests for strobes, write decode, bus and sleep.
module bsram_front_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = 4;
    localparam int W  = 36;

    // {mode, start low bits, expected low bits of word 0..3}
    localparam logic [10:0] VEC [8] = '{
        11'h01B, 11'h16C, 11'h2B1, 11'h3C6,
        11'h41B, 11'h54E, 11'h6B1, 11'h7E4
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          en_a_n, en_b, en_c_n, cpu_stb_n, ctl_stb_n, adv_n;
    logic          gwr_n, bwe_n, oe_n, sleep, ilv_mode;
    logic [3:0]    lane_n;
    logic          drv_en;
    logic [W-1:0]  drv_dat;
    wire  [W-1:0]  dq;

    logic [W-1:0]  ref_mem [16];
    logic [W-1:0]  obs;
    logic          oe_chk;
    int            checks = 0;
    int            fails  = 0;
    bit            done   = 1'b0;

    assign dq = drv_en ? drv_dat : {W{1'bz}};

    always #10 clk = ~clk;

    bsram_front #(.ADDR_W(AW)) u_bsram_front (
        .clk(clk), .rst_n(rst_n), .addr(addr), .en_a_n(en_a_n), .en_b(en_b),
        .en_c_n(en_c_n), .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n),
        .adv_n(adv_n), .gwr_n(gwr_n), .bwe_n(bwe_n), .lane_n(lane_n),
        .oe_n(oe_n), .sleep(sleep), .ilv_mode(ilv_mode), .dq(dq)
    );

    function automatic logic [W-1:0] pat(input logic [3:0] a);
        return {1'b1, a, 4'd3, 1'b0, a, 4'd2, 1'b1, a, 4'd1, 1'b0, a, 4'd0};
    endfunction

    task automatic idle();
        cpu_stb_n = 1'b1; ctl_stb_n = 1'b1; adv_n = 1'b1;
        gwr_n = 1'b1; bwe_n = 1'b1; lane_n = 4'hF; sleep = 1'b0;
        en_a_n = 1'b0; en_b = 1'b1; en_c_n = 1'b0;
        drv_en = 1'b0; oe_n = 1'b1; oe_chk = 1'b0;
    endtask

    // One edge; then sample the bus at the falling edge with the bench released.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        drv_en = 1'b0;
        oe_n   = oe_chk;
        #1;
        obs = dq;
        idle();
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_rel(input string req);
        checks++;
        if (!((obs === {W{1'bz}}) || (obs === {W{1'b0}}))) begin
            fails++;
            $display("FAIL %s actual=%h expected=released", req, obs);
        end
    endtask

    task automatic rd(input logic [3:0] a);
        cpu_stb_n = 1'b0; addr = a; tick();
    endtask

    task automatic wr_word(input logic [3:0] a, input logic [W-1:0] d);
        ctl_stb_n = 1'b0; addr = a; gwr_n = 1'b0; drv_en = 1'b1; drv_dat = d;
        tick();
        ref_mem[a] = d;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [10:0] v;
        logic [3:0]  a;
        string       req;
        rst_n = 1'b0; ilv_mode = 1'b0; addr = '0; drv_dat = '0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: released after reset
        tick();
        chk_rel("R1 after reset");

        // R8 write via controller strobe, R11 released after write
        for (int i = 0; i < 16; i++) begin
            wr_word(4'(i), pat(4'(i)));
            chk_rel("R11 after write");
        end
        ctl_stb_n = 1'b0; addr = 4'd3; tick();
        chk("R8 controller read", obs, ref_mem[3]);

        // R2/R3/R4 burst orders from the vector table
        for (int i = 0; i < 8; i++) begin
            v = VEC[i];
            ilv_mode = v[10];
            req = v[10] ? "R3/R4 interleaved" : "R2/R4 linear";
            a = {2'(i), v[9:8]};
            rd(a);
            chk(req, obs, ref_mem[a]);
            for (int k = 1; k < 4; k++) begin
                ilv_mode = ~v[10];  // mode only matters at load (R4)
                adv_n = 1'b0;
                tick();
                a = {2'(i), v[7-2*k -: 2]};
                chk(req, obs, ref_mem[a]);
            end
        end
        ilv_mode = 1'b0;

        // R10 suspend then advance
        rd(4'd9);
        chk("R10 first", obs, ref_mem[9]);
        tick();
        chk("R10 suspend", obs, ref_mem[9]);
        adv_n = 1'b0; tick();
        chk("R10 advance", obs, ref_mem[10]);

        // R6 processor strobe ignored with en_a_n high
        rd(4'd12);
        chk("R6 first", obs, ref_mem[12]);
        cpu_stb_n = 1'b0; en_a_n = 1'b1; adv_n = 1'b0; addr = 4'd0; tick();
        chk("R6 continue", obs, ref_mem[13]);

        // R5 processor strobe reads despite write; next cycle writes lane 0 (R9)
        cpu_stb_n = 1'b0; addr = 4'd5; gwr_n = 1'b0; drv_en = 1'b1; drv_dat = 36'hF_1111_2222;
        tick();
        chk("R5 strobe reads", obs, ref_mem[5]);
        bwe_n = 1'b0; lane_n = 4'b1110; drv_en = 1'b1; drv_dat = 36'h3_3333_3333;
        tick();
        chk_rel("R11 write cycle");
        ref_mem[5][8:0] = 9'h133;
        rd(4'd5);
        chk("R5/R9 lane write", obs, ref_mem[5]);

        // R7 both strobes: processor wins, no write
        cpu_stb_n = 1'b0; ctl_stb_n = 1'b0; addr = 4'd6; gwr_n = 1'b0;
        drv_en = 1'b1; drv_dat = 36'hA_AAAA_5555;
        tick();
        chk("R7 read", obs, ref_mem[6]);
        rd(4'd6);
        chk("R7 unchanged", obs, ref_mem[6]);

        // R9 byte-write with no lane selected, or lanes without bwe_n, is a read
        ctl_stb_n = 1'b0; addr = 4'd7; bwe_n = 1'b0; lane_n = 4'hF; tick();
        chk("R9 no lane", obs, ref_mem[7]);
        ctl_stb_n = 1'b0; addr = 4'd7; bwe_n = 1'b1; lane_n = 4'h0; tick();
        chk("R9 bwe high", obs, ref_mem[7]);
        ctl_stb_n = 1'b0; addr = 4'd11; gwr_n = 1'b0; lane_n = 4'hF;
        drv_en = 1'b1; drv_dat = 36'h5_0A0A_0C0C;
        tick();
        ref_mem[11] = 36'h5_0A0A_0C0C;
        rd(4'd11);
        chk("R9 global write", obs, ref_mem[11]);

        // R11 deselect and output enable
        ctl_stb_n = 1'b0; en_b = 1'b0; addr = 4'd4; tick();
        chk_rel("R11 deselect");
        adv_n = 1'b0; tick();
        chk_rel("R11 closed burst");
        cpu_stb_n = 1'b0; en_c_n = 1'b1; addr = 4'd4; tick();
        chk_rel("R11 cpu deselect");
        adv_n = 1'b0; gwr_n = 1'b0; drv_en = 1'b1; drv_dat = 36'h6_6666_6666; tick();
        chk_rel("R11 closed write");
        rd(4'd4);
        chk("R11 no write when closed", obs, ref_mem[4]);
        cpu_stb_n = 1'b0; addr = 4'd1; oe_chk = 1'b1; tick();
        chk_rel("R11 oe high");

        // R12 sleep
        rd(4'd2);
        chk("R12 first", obs, ref_mem[2]);
        sleep = 1'b1; gwr_n = 1'b0; drv_en = 1'b1; drv_dat = 36'h7_7777_7777; tick();
        chk_rel("R12 sleep write");
        tick();
        chk("R12 after sleep", obs, ref_mem[2]);
        sleep = 1'b1; cpu_stb_n = 1'b0; addr = 4'd14; tick();
        chk_rel("R12 sleep strobe");
        tick();
        chk("R12 burst kept", obs, ref_mem[2]);

        // R1 strobe-free write right after a reset does nothing
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        adv_n = 1'b0; gwr_n = 1'b0; drv_en = 1'b1; drv_dat = 36'h0_0F0F_0F0F; tick();
        chk_rel("R1 no burst");
        rd(4'd0);
        chk("R1 no write", obs, ref_mem[0]);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule